// File: doc/BRIEF.md
# Wait-State and System-Bus Ready Controller

This block sits next to an 8-bit processor and decides, for every bus cycle, whether the cycle may end at once or must be stretched. It decodes the cycle's address and its memory/IO indication. A cycle that lands on the board's own ROM, RAM or I/O ports counts as an early acknowledge, so READY stays high and no wait state is added. The block also drives the chip selects of those local devices.

Any other cycle goes out to the shared system bus. The controller raises a bus request on a falling edge of the bus clock and waits for the grant, which it samples on the same edge. It then enables the address and data drivers and holds READY low until the addressed slave pulls its transfer acknowledge low. When the processor drops its strobe, the bus is handed back on the next falling edge of the bus clock.

All outputs are registered. The bus clock arrives as a plain input and is brought into the controller clock domain before its falling edges are detected.

Top module: `bus_ready_ctrl`

## Requirements
- R1: While a command (rd_n or wr_n low) addresses an on-board device, ready stays 1 on every clock.
- R2: No bus request is made and ready stays 1 while both rd_n and wr_n are high, whatever the address.
- R3: For an off-board command, ready is 0 from the clock after the command is first sampled. It stays 0 until xack_n is sampled low while the drivers are enabled, and it is 1 again one clock after that sample.
- R4: After reset and when idle, breq_n=1 and bpro_n=0. A request sets breq_n=0 and bpro_n=1 in the same clock.
- R5: breq_n falls only one clock after a falling edge of bclk, seen through SYNC_STAGES flops. While bclk does not toggle, no request is made.
- R6: adr_en_n goes low only on a bclk falling edge where bgnt_n is sampled low. Without a grant the drivers stay off.
- R7: After the strobes return high following an acknowledged off-board cycle, the next bclk falling edge sets breq_n=1, adr_en_n=1 and bpro_n=0.
- R8: Once the drivers are enabled, removing the grant does not disable them before xack_n ends the transfer.
- R9: ROM with rom_big=0 spans 0x0000-0x07FF and addr[10] picks the half. With rom_big=1 it spans 0x0000-0x0FFF and addr[11] picks the half. Bit 0 of rom_cs_n is the lower half. A ROM chip select is driven low only for a memory read (io_m=0, rd_n=0), one clock after the read is sampled.
- R10: RAM spans 0x1000-0x11FF as two 256-byte banks, and addr[8] selects the bank (ram_cs_n[0] lower). The RAM select follows a memory read or write one clock later.
- R11: With io_m=1, port addresses whose addr[7:0] lie in 0xF0-0xF7 drive io_cs_n low, whether the cycle reads or writes. Every other I/O address is off-board, even when the same address would hit memory.
- R12: A memory write into the ROM range is an on-board hit: it adds no wait state and drives no chip select.
- R13: After reset, ready=1, adr_en_n=1 and every chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Cycle address |
| io_m | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bclk | input | 1 | System bus clock (sampled) |
| bgnt_n | input | 1 | Bus grant, active low |
| xack_n | input | 1 | Transfer acknowledge from slave, active low |
| rom_big | input | 1 | ROM size jumper: 0 = 2K, 1 = 4K |
| ready | output | 1 | Processor ready |
| breq_n | output | 1 | Bus request, active low |
| bpro_n | output | 1 | Priority out, active low |
| adr_en_n | output | 1 | Address/data driver enable, active low |
| rom_cs_n | output | 2 | ROM half chip selects, active low |
| ram_cs_n | output | 2 | RAM bank chip selects, active low |
| io_cs_n | output | 1 | On-board I/O port select, active low |

## Verification
The bench uses the default parameters: a 16-bit address, two ROM halves of 1K base size, RAM at 0x1000 in two 256-byte banks, I/O ports at 0xF0-0xF7, and two bclk synchronizer stages. With these values both ROM jumper settings, both RAM banks and the I/O window can be reached by a small table that also covers the edges of each range. The bus clock can be stopped and the grant delayed or withdrawn, which exposes request timing, grant gating and bus ownership. Off-board cycles are acknowledged after several different latencies.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_GRANT,
    ST_XFER,
    ST_DONE,
    ST_REL
  } arb_state_t;

  typedef struct packed {
    logic       onboard;
    logic       rom_hit;
    logic [1:0] rom_sel;
    logic       io_sel;
  } dec_core_t;

endpackage

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
#(
  parameter int                    ADDR_W     = 16,
  parameter int                    ROM_HALF_W = 10,
  parameter int                    RAM_BANK_W = 8,
  parameter int                    RAM_BANKS  = 2,
  parameter logic [ADDR_W-1:0]     RAM_BASE   = 16'h1000,
  parameter int                    IO_PORT_W  = 8,
  parameter int                    IO_SPAN_W  = 3,
  parameter logic [IO_PORT_W-1:0]  IO_BASE    = 8'hF0
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 io_m,
  input  logic                 rom_big,
  output dec_core_t            dec,
  output logic [RAM_BANKS-1:0] ram_sel
);

  localparam int BANK_SEL_W = $clog2(RAM_BANKS);
  localparam int RAM_W      = RAM_BANK_W + BANK_SEL_W;

  logic rom_small_in, rom_big_in, rom_in, rom_hi;
  logic ram_in, io_in;

  always_comb begin
    rom_small_in = (addr[ADDR_W-1:ROM_HALF_W+1] == '0);
    rom_big_in   = (addr[ADDR_W-1:ROM_HALF_W+2] == '0);
    rom_in       = rom_big ? rom_big_in : rom_small_in;
    rom_hi       = rom_big ? addr[ROM_HALF_W+1] : addr[ROM_HALF_W];
    ram_in       = (addr[ADDR_W-1:RAM_W] == RAM_BASE[ADDR_W-1:RAM_W]);
    io_in        = (addr[IO_PORT_W-1:IO_SPAN_W] == IO_BASE[IO_PORT_W-1:IO_SPAN_W]);
  end

  generate
    for (genvar b = 0; b < RAM_BANKS; b++) begin : g_bank
      assign ram_sel[b] = !io_m && ram_in &&
                          (addr[RAM_W-1:RAM_BANK_W] == BANK_SEL_W'(b));
    end
  endgenerate

  always_comb begin
    dec.rom_hit = !io_m && rom_in;
    dec.rom_sel = {dec.rom_hit & rom_hi, dec.rom_hit & ~rom_hi};
    dec.io_sel  = io_m && io_in;
    dec.onboard = io_m ? io_in : (rom_in || ram_in);
  end

endmodule

// File: rtl/brc_edge.sv
module brc_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk,
  output logic fall
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], bclk};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall = last_q && !sync_q[STAGES-1];

endmodule

// File: rtl/brc_arbiter.sv
module brc_arbiter
  import brc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd,
  input  logic onboard,
  input  logic bclk_fall,
  input  logic bgnt_n,
  input  logic xack_n,
  output logic ready,
  output logic breq_n,
  output logic bpro_n,
  output logic adr_en_n
);

  arb_state_t st;
  logic       bus_ctl;
  logic       xfer_done;
  logic       offboard_cmd;

  assign bus_ctl      = !adr_en_n;
  assign xfer_done    = bus_ctl && !xack_n;
  assign offboard_cmd = cmd && !onboard;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ready    <= 1'b1;
      breq_n   <= 1'b1;
      bpro_n   <= 1'b0;
      adr_en_n <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: begin
          if (offboard_cmd) begin
            ready <= 1'b0;
            st    <= ST_REQ;
          end else begin
            ready <= 1'b1;
          end
        end
        ST_REQ: begin
          if (bclk_fall) begin
            breq_n <= 1'b0;
            bpro_n <= 1'b1;
            st     <= ST_GRANT;
          end
        end
        ST_GRANT: begin
          if (bclk_fall && !bgnt_n) begin
            adr_en_n <= 1'b0;
            st       <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (xfer_done) begin
            ready <= 1'b1;
            st    <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (!cmd) st <= ST_REL;
        end
        ST_REL: begin
          if (offboard_cmd) ready <= 1'b0;
          if (bclk_fall) begin
            breq_n   <= 1'b1;
            bpro_n   <= 1'b0;
            adr_en_n <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_WAIT_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    (st == ST_XFER && xack_n) |=> !ready); // R3
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (st == ST_XFER && !xack_n) |=> ready); // R3
  AST_PRIO_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    !breq_n |-> bpro_n); // R4
  AST_REQ_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $fell(breq_n) |-> $past(bclk_fall)); // R5
  AST_DRV_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    $fell(adr_en_n) |-> $past(bclk_fall && !bgnt_n)); // R6
  AST_KEEP_OWNERSHIP: assert property (@(posedge clk) disable iff (rst)
    (!adr_en_n && !ready) |=> !adr_en_n); // R8

endmodule

// File: rtl/bus_ready_ctrl.sv
module bus_ready_ctrl
  import brc_pkg::*;
#(
  parameter int                    ADDR_W      = 16,
  parameter int                    ROM_HALF_W  = 10,
  parameter int                    RAM_BANK_W  = 8,
  parameter int                    RAM_BANKS   = 2,
  parameter logic [ADDR_W-1:0]     RAM_BASE    = 16'h1000,
  parameter int                    IO_PORT_W   = 8,
  parameter int                    IO_SPAN_W   = 3,
  parameter logic [IO_PORT_W-1:0]  IO_BASE     = 8'hF0,
  parameter int                    SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 io_m,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic                 bclk,
  input  logic                 bgnt_n,
  input  logic                 xack_n,
  input  logic                 rom_big,
  output logic                 ready,
  output logic                 breq_n,
  output logic                 bpro_n,
  output logic                 adr_en_n,
  output logic [1:0]           rom_cs_n,
  output logic [RAM_BANKS-1:0] ram_cs_n,
  output logic                 io_cs_n
);

  dec_core_t            dec;
  logic [RAM_BANKS-1:0] ram_sel;
  logic                 cmd;
  logic                 mem_rd;
  logic                 bclk_fall;

  assign cmd    = !rd_n || !wr_n;
  assign mem_rd = !rd_n && !io_m;

  brc_decode #(
    .ADDR_W(ADDR_W), .ROM_HALF_W(ROM_HALF_W), .RAM_BANK_W(RAM_BANK_W),
    .RAM_BANKS(RAM_BANKS), .RAM_BASE(RAM_BASE), .IO_PORT_W(IO_PORT_W),
    .IO_SPAN_W(IO_SPAN_W), .IO_BASE(IO_BASE)
  ) i_decode (
    .addr(addr), .io_m(io_m), .rom_big(rom_big), .dec(dec), .ram_sel(ram_sel)
  );

  brc_edge #(.STAGES(SYNC_STAGES)) i_edge (
    .clk(clk), .rst(rst), .bclk(bclk), .fall(bclk_fall)
  );

  brc_arbiter i_arb (
    .clk(clk), .rst(rst), .cmd(cmd), .onboard(dec.onboard),
    .bclk_fall(bclk_fall), .bgnt_n(bgnt_n), .xack_n(xack_n),
    .ready(ready), .breq_n(breq_n), .bpro_n(bpro_n), .adr_en_n(adr_en_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_cs_n <= '1;
      ram_cs_n <= '1;
      io_cs_n  <= 1'b1;
    end else begin
      rom_cs_n <= ~(dec.rom_sel & {2{mem_rd}});
      ram_cs_n <= ~(ram_sel & {RAM_BANKS{cmd}});
      io_cs_n  <= ~(dec.io_sel && cmd);
    end
  end

  AST_ONBOARD_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
    (cmd && dec.onboard && ready) |=> ready); // R1
  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~{rom_cs_n, ram_cs_n, io_cs_n})); // R9
  AST_ROM_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    (rom_cs_n != 2'b11) |-> $past(mem_rd)); // R12

endmodule

// File: tb/test_bus_ready_ctrl.sv
module test_bus_ready_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  typedef struct packed {
    logic        io_m;
    logic        rd;
    logic        wr;
    logic [15:0] addr;
    logic        big;
    logic [1:0]  rom;
    logic [1:0]  ram;
    logic        io;
    logic        rdy;
    logic [3:0]  lat;
  } vec_t;

  // rd/wr and chip selects are active high in this table
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,16'h0000,1'b0,2'b01,2'b00,1'b0,1'b1,4'd0}, // R9
    '{1'b0,1'b1,1'b0,16'h0400,1'b0,2'b10,2'b00,1'b0,1'b1,4'd0}, // R9
    '{1'b0,1'b1,1'b0,16'h07FF,1'b0,2'b10,2'b00,1'b0,1'b1,4'd0}, // R9
    '{1'b0,1'b1,1'b0,16'h0800,1'b0,2'b00,2'b00,1'b0,1'b0,4'd0}, // R9 miss
    '{1'b0,1'b1,1'b0,16'h0800,1'b1,2'b10,2'b00,1'b0,1'b1,4'd0}, // R9
    '{1'b0,1'b1,1'b0,16'h0400,1'b1,2'b01,2'b00,1'b0,1'b1,4'd0}, // R9
    '{1'b0,1'b1,1'b0,16'h0FFF,1'b1,2'b10,2'b00,1'b0,1'b1,4'd0}, // R9
    '{1'b0,1'b1,1'b0,16'h1000,1'b0,2'b00,2'b01,1'b0,1'b1,4'd0}, // R10
    '{1'b0,1'b0,1'b1,16'h11FF,1'b0,2'b00,2'b10,1'b0,1'b1,4'd0}, // R10
    '{1'b0,1'b0,1'b1,16'h0100,1'b0,2'b00,2'b00,1'b0,1'b1,4'd0}, // R12
    '{1'b0,1'b1,1'b0,16'h1200,1'b0,2'b00,2'b00,1'b0,1'b0,4'd2}, // R10 miss
    '{1'b1,1'b1,1'b0,16'hF0F0,1'b0,2'b00,2'b00,1'b1,1'b1,4'd0}, // R11
    '{1'b1,1'b0,1'b1,16'h00F7,1'b0,2'b00,2'b00,1'b1,1'b1,4'd0}, // R11
    '{1'b1,1'b1,1'b0,16'h00F8,1'b0,2'b00,2'b00,1'b0,1'b0,4'd5}, // R11 miss
    '{1'b1,1'b1,1'b0,16'h0000,1'b0,2'b00,2'b00,1'b0,1'b0,4'd3}  // R11 miss
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        io_m = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic        bclk = 1'b0, bgnt_n = 1'b1, xack_n = 1'b1, rom_big = 1'b0;
  logic        bclk_run = 1'b1;
  logic        ready, breq_n, bpro_n, adr_en_n, io_cs_n;
  logic [1:0]  rom_cs_n, ram_cs_n;
  int          n_checks = 0, n_fail = 0;

  bus_ready_ctrl i_bus_ready_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
    .bclk(bclk), .bgnt_n(bgnt_n), .xack_n(xack_n), .rom_big(rom_big),
    .ready(ready), .breq_n(breq_n), .bpro_n(bpro_n), .adr_en_n(adr_en_n),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .io_cs_n(io_cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      if (bclk_run) bclk = ~bclk;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic complete_offboard(input int lat, input int grant_delay, input bit drop_grant);
    int cnt;
    cnt = 0;
    while (breq_n && cnt < 60) begin @(negedge clk); cnt++; end
    check(!breq_n && bpro_n, "R4 request with priority out", {breq_n, bpro_n}, 2'b01);
    check(adr_en_n, "R6 drivers off before grant", adr_en_n, 1);
    repeat (grant_delay) @(negedge clk);
    if (grant_delay > 0) check(adr_en_n, "R6 no grant keeps drivers off", adr_en_n, 1);
    bgnt_n = 1'b0;
    cnt = 0;
    while (adr_en_n && cnt < 60) begin @(negedge clk); cnt++; end
    check(!adr_en_n, "R6 drivers on after grant", adr_en_n, 0);
    check(!ready, "R3 ready low before ack", ready, 0);
    if (drop_grant) begin
      bgnt_n = 1'b1;
      repeat (10) @(negedge clk);
      check(!adr_en_n, "R8 ownership kept", adr_en_n, 0);
    end
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      check(!ready, "R3 ready low during latency", ready, 0);
    end
    xack_n = 1'b0;
    @(negedge clk);
    check(ready, "R3 ready one clock after ack", ready, 1);
    rd_n = 1'b1; wr_n = 1'b1; xack_n = 1'b1; bgnt_n = 1'b1;
    cnt = 0;
    while (!breq_n && cnt < 60) begin @(negedge clk); cnt++; end
    check(breq_n && adr_en_n && !bpro_n, "R7 release",
          {breq_n, adr_en_n, bpro_n}, 3'b110);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check(ready && adr_en_n && rom_cs_n == 2'b11 && ram_cs_n == 2'b11 && io_cs_n,
          "R13 reset outputs", {ready, adr_en_n, rom_cs_n, ram_cs_n, io_cs_n}, 7'h7F);
    check(breq_n && !bpro_n, "R4 idle request lines", {breq_n, bpro_n}, 2'b10);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      addr = VECS[k].addr; io_m = VECS[k].io_m; rom_big = VECS[k].big;
      rd_n = ~VECS[k].rd; wr_n = ~VECS[k].wr;
      @(negedge clk);
      check(ready == VECS[k].rdy, VECS[k].rdy ? "R1 no wait on-board" : "R3 wait off-board",
            ready, VECS[k].rdy);
      check(rom_cs_n == ~VECS[k].rom && ram_cs_n == ~VECS[k].ram && io_cs_n == ~VECS[k].io,
            "R9 R10 R11 R12 chip selects", {rom_cs_n, ram_cs_n, io_cs_n},
            {~VECS[k].rom, ~VECS[k].ram, ~VECS[k].io});
      if (VECS[k].rdy) begin
        repeat (4) @(negedge clk);
        check(ready && breq_n, "R1 ready held on-board", {ready, breq_n}, 2'b11);
        rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
      end else begin
        complete_offboard(int'(VECS[k].lat), 0, 1'b0);
      end
      @(negedge clk);
    end

    // R2 no command, no request
    addr = 16'h3000; io_m = 1'b0;
    repeat (10) @(negedge clk);
    check(breq_n && ready, "R2 idle without strobes", {breq_n, ready}, 2'b11);

    // R5 stopped bus clock blocks the request
    bclk_run = 1'b0;
    rd_n = 1'b0;
    repeat (12) @(negedge clk);
    check(breq_n && !ready, "R5 no request without bclk edge", {breq_n, ready}, 2'b10);
    bclk_run = 1'b1;
    complete_offboard(4, 15, 1'b1);

    // write off-board with immediate ack
    @(negedge clk);
    addr = 16'h8000; wr_n = 1'b0;
    @(negedge clk);
    check(!ready, "R3 off-board write waits", ready, 0);
    complete_offboard(1, 0, 1'b0);

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule